// File: doc/BRIEF.md
# Diverse Duplex Error-Checked Datapath Stage

This block is one pipeline stage that checks itself while it runs. An operand is captured in an input register. Two combinational copies of the same function read that register. The function is binary-to-reflected-Gray conversion, `y = x ^ (x >> 1)`. The two copies are built with different gate structures. The first uses an XOR network. The second uses an OR/AND/invert network. A comparator watches both copies. If they disagree when the result is captured, that is a logic error.

The result register is not duplicated. Extra parity flip-flops sit beside it instead. Each one holds the parity of one group of result bits. These parity bits are predicted from the input register, not from the computed result, so the parity tree runs in parallel with the logic rather than after it. Every cycle, the stored result is re-checked against its stored parity. The comparator error and the parity error both feed one sticky error flag. That flag stays set until software-independent control logic issues a synchronous clear.

Test inputs let a stuck value be forced onto one output net of either copy, or of both. Another test input inverts one bit of the result as it is stored. Together these reach both detection paths.

Top module: `ced_duplex_stage`

## Requirements
- R1: While and after reset, `z_o` is 0 and `cmp_err_o`, `par_err_o` and `err_o` are all 0.
- R2: Two rising edges after a cycle with `ld_i`=1, `z_o` equals `din ^ (din >> 1)` of the captured operand.
- R3: While `ld_i` is 0, neither the operand register nor `z_o` changes, whatever `din_i` does.
- R4: `flt_sel_i` selects where a stuck value is forced. 0 means no fault. 1 means the primary copy, which feeds `z_o`. 2 means the secondary copy. 3 means both copies. The forced net is bit `flt_idx_i` of the selected copy's output, and the forced value is `flt_val_i`. The fault inputs act in the cycle after `ld_i`.
- R5: `cmp_err_o` is updated at each result capture. It is 1 exactly when the two copies disagree at that capture. That happens when only one copy is faulted and the forced value differs from the correct bit.
- R6: Parity group k holds the result bits whose index mod `GROUPS` equals k. `par_err_o` is 1 when any group parity of the stored result differs from the parity predicted from the operand.
- R7: `flip_en_i`=1 during capture inverts stored result bit `flip_idx_i`. This leaves the stored parity as predicted, so `par_err_o` rises.
- R8: Parity catches a common-mode fault. The same stuck value in both copies gives no comparator error, but does give a parity error when the value is wrong.
- R9: `err_o` sets at the edge that captures a comparator mismatch, or one edge after `par_err_o` is high. It then stays set, also across later clean captures, until `clr_i`. `clr_i` clears it at the next edge and has priority over new errors.

Note: `flt_sel_i` acts as a fault-location selector in its own right, separate from the per-copy enables it drives internally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| ld_i | input | 1 | Capture `din_i` into the operand register |
| din_i | input | WIDTH | Operand |
| clr_i | input | 1 | Synchronous clear of the sticky error |
| flt_sel_i | input | 2 | Stuck-fault location: 0 none, 1 primary, 2 secondary, 3 both |
| flt_idx_i | input | IDXW | Output bit index of the forced net |
| flt_val_i | input | 1 | Forced stuck value |
| flip_en_i | input | 1 | Invert one stored result bit at capture |
| flip_idx_i | input | IDXW | Index of the bit to invert |
| z_o | output | WIDTH | Stored result |
| cmp_err_o | output | 1 | Copies disagreed at the last capture |
| par_err_o | output | 1 | Stored result fails its group parity |
| err_o | output | 1 | Sticky OR of both error paths |

## Verification
The bench sweeps every 8-bit operand fault-free. It then forces every bit to both stuck values in each copy and in both copies. This separates faults that agree with the correct bit, which must stay silent, from faults that differ. A comparator that compared the wrong nets, or reported a silent fault, would show up here.

A fault in both copies must escape the comparator but still raise parity. A design that predicted parity from the computed result, rather than from the operand, would miss it.

Single-bit flips at every index check the modulo grouping. A wrong group mask would leave some flips unflagged.

The bench also checks two things about the sticky flag. It must survive a clean recapture, and it must drop only on clear. A flag that followed the instantaneous errors would fail the first of these.

// File: rtl/ced_pkg.sv
package ced_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_PRI  = 2'd1,
    FLT_SEC  = 2'd2,
    FLT_BOTH = 2'd3
  } flt_loc_e;
endpackage

// File: rtl/ced_logic_copy.sv
// One implementation of the Gray conversion; STRUCT picks the gate structure.
module ced_logic_copy #(
  parameter int WIDTH  = 8,
  parameter int STRUCT = 0,
  localparam int IDXW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic             stuck_en_i,
  input  logic [IDXW-1:0]  stuck_idx_i,
  input  logic             stuck_val_i,
  output logic [WIDTH-1:0] y_o
);
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] raw;

  assign shifted = x_i >> 1;

  generate
    if (STRUCT == 0) begin : g_xor
      assign raw = x_i ^ shifted;
    end else begin : g_andor
      assign raw = (x_i | shifted) & ~(x_i & shifted);
    end
  endgenerate

  always_comb begin
    y_o = raw;
    if (stuck_en_i) y_o[stuck_idx_i] = stuck_val_i;
  end
endmodule

// File: rtl/ced_par_pred.sv
// Predicts per-group parity of the Gray result straight from the operand.
module ced_par_pred #(
  parameter int WIDTH  = 8,
  parameter int GROUPS = 3
) (
  input  logic [WIDTH-1:0]  x_i,
  output logic [GROUPS-1:0] par_o
);
  logic [WIDTH-1:0] shifted;
  assign shifted = x_i >> 1;

  generate
    for (genvar k = 0; k < GROUPS; k++) begin : g_grp
      always_comb begin
        par_o[k] = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
          if (i % GROUPS == k) par_o[k] = par_o[k] ^ x_i[i] ^ shifted[i];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/ced_par_check.sv
// Recomputes group parity of the stored result and compares with the stored bits.
module ced_par_check #(
  parameter int WIDTH  = 8,
  parameter int GROUPS = 3
) (
  input  logic [WIDTH-1:0]  z_i,
  input  logic [GROUPS-1:0] par_i,
  output logic              err_o
);
  logic [GROUPS-1:0] grp_bad;

  generate
    for (genvar k = 0; k < GROUPS; k++) begin : g_grp
      always_comb begin
        grp_bad[k] = par_i[k];
        for (int i = 0; i < WIDTH; i++) begin
          if (i % GROUPS == k) grp_bad[k] = grp_bad[k] ^ z_i[i];
        end
      end
    end
  endgenerate

  assign err_o = |grp_bad;
endmodule

// File: rtl/ced_duplex_stage.sv
module ced_duplex_stage #(
  parameter int WIDTH  = 8,
  parameter int GROUPS = 3,
  localparam int IDXW  = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             clr_i,
  input  logic [1:0]       flt_sel_i,
  input  logic [IDXW-1:0]  flt_idx_i,
  input  logic             flt_val_i,
  input  logic             flip_en_i,
  input  logic [IDXW-1:0]  flip_idx_i,
  output logic [WIDTH-1:0] z_o,
  output logic             cmp_err_o,
  output logic             par_err_o,
  output logic             err_o
);
  import ced_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic [WIDTH-1:0]  x_q, x_n;
  logic              ld_q;
  logic [WIDTH-1:0]  z_q, z_n;
  logic [GROUPS-1:0] zpar_q, zpar_n;
  logic              cmp_q, cmp_n;
  logic              err_q, err_n;
  logic [WIDTH-1:0]  out_a, out_b;
  logic [GROUPS-1:0] par_pred;
  logic              cmp_mis;
  logic              par_bad;
  logic              flt_a, flt_b;

  assign flt_a = (flt_loc_e'(flt_sel_i) == FLT_PRI) || (flt_loc_e'(flt_sel_i) == FLT_BOTH);
  assign flt_b = (flt_loc_e'(flt_sel_i) == FLT_SEC) || (flt_loc_e'(flt_sel_i) == FLT_BOTH);

  ced_logic_copy #(.WIDTH(WIDTH), .STRUCT(0)) i_copy_pri (
    .x_i(x_q), .stuck_en_i(flt_a), .stuck_idx_i(flt_idx_i),
    .stuck_val_i(flt_val_i), .y_o(out_a)
  );

  ced_logic_copy #(.WIDTH(WIDTH), .STRUCT(1)) i_copy_sec (
    .x_i(x_q), .stuck_en_i(flt_b), .stuck_idx_i(flt_idx_i),
    .stuck_val_i(flt_val_i), .y_o(out_b)
  );

  ced_par_pred #(.WIDTH(WIDTH), .GROUPS(GROUPS)) i_pred (
    .x_i(x_q), .par_o(par_pred)
  );

  ced_par_check #(.WIDTH(WIDTH), .GROUPS(GROUPS)) i_check (
    .z_i(z_q), .par_i(zpar_q), .err_o(par_bad)
  );

  assign cmp_mis = (out_a != out_b);

  always_comb begin
    x_n    = x_q;
    z_n    = z_q;
    zpar_n = zpar_q;
    cmp_n  = cmp_q;
    if (ld_i) x_n = din_i;
    if (ld_q) begin
      z_n    = out_a ^ (flip_en_i ? (WIDTH'(1) << flip_idx_i) : '0);
      zpar_n = par_pred;
      cmp_n  = cmp_mis;
    end
    if (clr_i) err_n = 1'b0;
    else       err_n = err_q | (ld_q & cmp_mis) | par_bad;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      ld_q   <= 1'b0;
      z_q    <= '0;
      zpar_q <= '0;
      cmp_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      x_q    <= x_n;
      ld_q   <= ld_i;
      z_q    <= z_n;
      zpar_q <= zpar_n;
      cmp_q  <= cmp_n;
      err_q  <= err_n;
    end
  end

  assign z_o       = z_q;
  assign cmp_err_o = cmp_q;
  assign par_err_o = par_bad;
  assign err_o     = err_q;
endmodule

// File: rtl/ced_duplex_stage_chk.sv
module ced_duplex_stage_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ld_i,
  input logic             clr_i,
  input logic             ld_q,
  input logic [WIDTH-1:0] x_q,
  input logic [WIDTH-1:0] out_a,
  input logic [WIDTH-1:0] out_b,
  input logic [1:0]       flt_sel_i,
  input logic             par_err_o,
  input logic             err_o
);
  AST_OPERAND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(x_q)); // R3
  AST_COPIES_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_q && flt_sel_i == 2'b00) |-> (out_a == out_b)); // R2
  AST_MISMATCH_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_q && out_a != out_b && !clr_i) |=> err_o); // R5
  AST_PARITY_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_err_o && !clr_i) |=> err_o); // R6
  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr_i) |=> err_o); // R9
  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !err_o); // R9
endmodule

bind ced_duplex_stage ced_duplex_stage_chk #(.WIDTH(WIDTH)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(ld_i), .clr_i(clr_i), .ld_q(ld_q),
  .x_q(x_q), .out_a(out_a), .out_b(out_b), .flt_sel_i(flt_sel_i),
  .par_err_o(par_err_o), .err_o(err_o)
);

// File: tb/test_ced_duplex_stage.sv
module test_ced_duplex_stage;
  localparam int W = 8;
  localparam int G = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ld = 1'b0;
  logic [W-1:0] din = '0;
  logic         clr = 1'b0;
  logic [1:0]   fsel = 2'b00;
  logic [2:0]   fidx = '0;
  logic         fval = 1'b0;
  logic         flip = 1'b0;
  logic [2:0]   flidx = '0;
  logic [W-1:0] z;
  logic         cmp_err, par_err, err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ced_duplex_stage #(.WIDTH(W), .GROUPS(G)) i_ced_duplex_stage (
    .clk_i(clk), .rst_ni(rst_n), .ld_i(ld), .din_i(din), .clr_i(clr),
    .flt_sel_i(fsel), .flt_idx_i(fidx), .flt_val_i(fval),
    .flip_en_i(flip), .flip_idx_i(flidx),
    .z_o(z), .cmp_err_o(cmp_err), .par_err_o(par_err), .err_o(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] gray(input logic [W-1:0] x);
    return x ^ (x >> 1);
  endfunction

  // one capture with optional fault, then a clean capture and a clear
  task automatic run_op(input logic [W-1:0] x, input int sel, input int b,
                        input int v, input int fl, input int fli);
    logic [W-1:0] g, ze, d;
    int exp_cmp, exp_par;
    g  = gray(x);
    ze = g;
    if (sel == 1 || sel == 3) ze[b] = v[0];
    if (fl != 0) ze[fli] = ~ze[fli];
    exp_cmp = ((sel == 1 || sel == 2) && g[b] != v[0]) ? 1 : 0;
    d = ze ^ g;
    exp_par = 0;
    for (int k = 0; k < G; k++) begin
      logic p;
      p = 1'b0;
      for (int j = 0; j < W; j++) if (j % G == k) p = p ^ d[j];
      if (p) exp_par = 1;
    end

    @(negedge clk); ld = 1'b1; din = x;
    @(negedge clk); ld = 1'b0; din = ~x;
    fsel = 2'(sel); fidx = 3'(b); fval = v[0]; flip = fl[0]; flidx = 3'(fli);
    @(negedge clk);
    fsel = 2'b00; flip = 1'b0;
    chk("R2/R4 z_o", int'(z), int'(ze));
    chk("R5 cmp_err_o", int'(cmp_err), exp_cmp);
    chk("R6/R7/R8 par_err_o", int'(par_err), exp_par);
    @(negedge clk);
    chk("R3 z_o hold", int'(z), int'(ze));
    chk("R9 err_o set", int'(err), (exp_cmp | exp_par));
    ld = 1'b1; din = '0;
    @(negedge clk); ld = 1'b0;
    @(negedge clk);
    chk("R9 err_o sticky", int'(err), (exp_cmp | exp_par));
    chk("R6 par clean", int'(par_err), 0);
    clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk("R9 err_o cleared", int'(err), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 z_o reset", int'(z), 0);
    chk("R1 err reset", int'({cmp_err, par_err, err}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 z_o after reset", int'(z), 0);
    chk("R1 err after reset", int'({cmp_err, par_err, err}), 0);

    for (int x = 0; x < 256; x++) run_op(W'(x), 0, 0, 0, 0, 0);
    for (int s = 1; s < 4; s++)
      for (int b = 0; b < W; b++)
        for (int v = 0; v < 2; v++)
          for (int x = 3; x < 256; x += 37) run_op(W'(x), s, b, v, 0, 0);
    for (int f = 0; f < W; f++)
      for (int x = 5; x < 256; x += 50) run_op(W'(x), 0, 0, 0, 1, f);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule